// File: doc/BRIEF.md
# SD Command Issue Queue

This block sits between the register file of an SD/MMC host and its command-line engine. Software loads a 32-bit argument and then writes a command word whose start bit asks for the command to be sent. When the engine is free, the command is launched toward it at once. When the engine is busy, one further command is parked in a single holding slot, and its start bit stays visible to software until the slot is promoted to the engine. A command that arrives while both the engine and the slot are occupied is dropped, and a hardware-locked error is flagged.

The engine reports the end of each command, either as a received response (possibly marked erroneous) or as a response timeout. Either outcome raises a command-done status bit, and separate error bits record which way it ended. A command marked as clock-update-only goes to the clock block instead of the line engine. It completes by itself one cycle later and never raises command-done. The status bits are cleared by writing ones to them. A registered interrupt line is the OR of the status bits gated by a mask.

Top module: `sdq_cmd_queue`

## Requirements
- R1: The command word is 10 bits: bits [5:0] index, bit 6 response expected, bit 7 long response, bit 8 clock-update-only, bit 9 start. A command word write with bit 9 clear launches nothing, buffers nothing and leaves the status unchanged.
- R2: A start write while the engine and the slot are both empty launches in the next cycle. `issue_valid_o` pulses for one cycle with the index, response flags and argument. The argument is the value written in the same cycle, if any, or else the last value written. `start_pending_o` stays 0.
- R3: A start write while a command executes and the slot is empty is held in the slot. `start_pending_o` reads 1 from the next cycle until that command is promoted.
- R4: The held command launches in the cycle after the executing command completes, and `start_pending_o` clears in that same cycle. Two launches are never in consecutive cycles.
- R5: A start write while a command executes and the slot is full is discarded, and status bit 3 (hardware-locked error) is set. The executing and held commands are unaffected.
- R6: For an executing normal command, `eng_resp_i` or `eng_tout_i` completes it and sets status bit 0 (command done) in the next cycle. These inputs are ignored when nothing executes.
- R7: A completion by timeout also sets status bit 2. A completion by response with `eng_rerr_i` high sets status bit 1. If both inputs are high, the timeout wins.
- R8: A clock-update-only command pulses `clk_upd_o` instead of `issue_valid_o`. It completes on its own one cycle later, ignores the engine inputs, and never sets any status bit.
- R9: Writing ones with `sts_clr_en_i` clears those status bits. A status bit set in the same cycle as its clear stays set.
- R10: `irq_o` is the OR over all bits of status AND mask. It is updated in the same cycle as the status and the mask (written through `mask_wr_en_i`).
- R11: After synchronous reset, the queue is empty, nothing executes, status and mask are 0, and all outputs are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| arg_wr_en_i | input | 1 | Argument register write strobe |
| arg_wr_data_i | input | ARG_W | Argument write data |
| cmd_wr_en_i | input | 1 | Command word write strobe |
| cmd_wr_data_i | input | 10 | Command word (fields per R1) |
| sts_clr_en_i | input | 1 | Status write-one-to-clear strobe |
| sts_clr_data_i | input | 4 | Bits to clear |
| mask_wr_en_i | input | 1 | Interrupt mask write strobe |
| mask_wr_data_i | input | 4 | Interrupt mask value |
| eng_resp_i | input | 1 | Engine: response received |
| eng_tout_i | input | 1 | Engine: response timeout |
| eng_rerr_i | input | 1 | Engine: response had an error (with eng_resp_i) |
| issue_valid_o | output | 1 | One-cycle launch pulse to the line engine |
| issue_arg_o | output | ARG_W | Argument of the launched command |
| issue_index_o | output | 6 | Index of the launched command |
| issue_resp_o | output | 1 | Launched command expects a response |
| issue_long_o | output | 1 | Launched command expects a long response |
| clk_upd_o | output | 1 | One-cycle pulse to the clock block |
| start_pending_o | output | 1 | Start-bit readback: a command waits in the slot |
| status_o | output | 4 | Status: bit0 done, bit1 response error, bit2 timeout, bit3 locked error |
| irq_o | output | 1 | Masked interrupt |

## Verification
Two collisions need deliberate stimulus. The first is a completion from the engine in the same cycle as a software write-one-to-clear of command-done. The bench provokes it by driving both in one cycle and expects bit 0 to remain set. The second is a promotion from the slot in the same cycle as a fresh start write. The new command must take the slot that the promotion frees, and no locked error may appear. Random traffic produces this case many times, and each cycle is judged against a behavioural model that holds its pending command in a queue.

// File: rtl/sdq_pkg.sv
package sdq_pkg;
  localparam int CMD_W     = 10;
  localparam int IDX_W     = 6;
  localparam int RESP_BIT  = 6;
  localparam int LONG_BIT  = 7;
  localparam int CLK_BIT   = 8;
  localparam int START_BIT = 9;
  localparam int FIELD_W   = CMD_W - 1;   // command word without start bit
  localparam int ISS_W     = FIELD_W - 1; // fields sent to the line engine
  localparam int NSTS      = 4;
  localparam int ST_DONE   = 0;
  localparam int ST_RERR   = 1;
  localparam int ST_TOUT   = 2;
  localparam int ST_HLE    = 3;

  typedef struct packed {
    logic             clk_only;
    logic             lng;
    logic             resp;
    logic [IDX_W-1:0] idx;
  } cmd_fields_t;
endpackage

// File: rtl/sdq_slot.sv
module sdq_slot #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  always_ff @(posedge clk) begin
    if (rst) q <= '0;
    else if (load) q <= d;
  end
endmodule

// File: rtl/sdq_ctrl.sv
module sdq_ctrl (
  input  logic clk,
  input  logic rst,
  input  logic start_req,
  input  logic launch_clk_only,
  input  logic eng_end,
  output logic busy_o,
  output logic slot_full_o,
  output logic from_slot_o,
  output logic launch_o,
  output logic push_o,
  output logic reject_o,
  output logic normal_done_o
);
  logic busy_q, clk_exec_q, slot_q;
  logic clk_done;

  always_comb begin
    from_slot_o   = !busy_q && slot_q;
    launch_o      = from_slot_o || (!busy_q && !slot_q && start_req);
    push_o        = start_req && (busy_q ? !slot_q : slot_q);
    reject_o      = start_req && busy_q && slot_q;
    normal_done_o = busy_q && !clk_exec_q && eng_end;
    clk_done      = busy_q && clk_exec_q;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      busy_q     <= 1'b0;
      clk_exec_q <= 1'b0;
      slot_q     <= 1'b0;
    end else begin
      if (launch_o) begin
        busy_q     <= 1'b1;
        clk_exec_q <= launch_clk_only;
      end else if (normal_done_o || clk_done) begin
        busy_q <= 1'b0;
      end
      if (push_o) slot_q <= 1'b1;
      else if (from_slot_o) slot_q <= 1'b0;
    end
  end

  assign busy_o      = busy_q;
  assign slot_full_o = slot_q;
endmodule

// File: rtl/sdq_status.sv
module sdq_status #(
  parameter int N = 4
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] set_i,
  input  logic         clr_en_i,
  input  logic [N-1:0] clr_i,
  input  logic         mask_en_i,
  input  logic [N-1:0] mask_i,
  output logic [N-1:0] sts_o,
  output logic         irq_o
);
  logic [N-1:0] sts_q, sts_nx, mask_q, mask_nx;

  for (genvar b = 0; b < N; b++) begin : g_bit
    always_comb sts_nx[b] = set_i[b] | (sts_q[b] & ~(clr_en_i & clr_i[b]));
  end

  always_comb mask_nx = mask_en_i ? mask_i : mask_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      sts_q  <= '0;
      mask_q <= '0;
      irq_o  <= 1'b0;
    end else begin
      sts_q  <= sts_nx;
      mask_q <= mask_nx;
      irq_o  <= |(sts_nx & mask_nx);
    end
  end

  assign sts_o = sts_q;
endmodule

// File: rtl/sdq_cmd_queue.sv
module sdq_cmd_queue
  import sdq_pkg::*;
#(
  parameter int ARG_W = 32
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               arg_wr_en_i,
  input  logic [ARG_W-1:0]   arg_wr_data_i,
  input  logic               cmd_wr_en_i,
  input  logic [CMD_W-1:0]   cmd_wr_data_i,
  input  logic               sts_clr_en_i,
  input  logic [NSTS-1:0]    sts_clr_data_i,
  input  logic               mask_wr_en_i,
  input  logic [NSTS-1:0]    mask_wr_data_i,
  input  logic               eng_resp_i,
  input  logic               eng_tout_i,
  input  logic               eng_rerr_i,
  output logic               issue_valid_o,
  output logic [ARG_W-1:0]   issue_arg_o,
  output logic [IDX_W-1:0]   issue_index_o,
  output logic               issue_resp_o,
  output logic               issue_long_o,
  output logic               clk_upd_o,
  output logic               start_pending_o,
  output logic [NSTS-1:0]    status_o,
  output logic               irq_o
);
  localparam int SLOT_W = ARG_W + FIELD_W;
  localparam int OUT_W  = ARG_W + ISS_W;

  logic [ARG_W-1:0]  arg_q, arg_nx;
  logic              start_req;
  cmd_fields_t       new_f, slot_f, cand_f;
  logic [SLOT_W-1:0] slot_d, slot_q;
  logic [ARG_W-1:0]  slot_arg, cand_arg;
  logic [OUT_W-1:0]  out_d, out_q;
  logic              exec_busy, slot_full, from_slot, launch, push, reject, normal_done;
  logic [NSTS-1:0]   sts_set;

  // argument register, same-cycle write is forwarded
  always_comb arg_nx = arg_wr_en_i ? arg_wr_data_i : arg_q;
  always_ff @(posedge clk) begin
    if (rst) arg_q <= '0;
    else     arg_q <= arg_nx;
  end

  always_comb begin
    start_req = cmd_wr_en_i && cmd_wr_data_i[START_BIT];
    new_f     = cmd_fields_t'(cmd_wr_data_i[FIELD_W-1:0]);
    slot_d    = {arg_nx, new_f};
    slot_arg  = slot_q[SLOT_W-1:FIELD_W];
    slot_f    = cmd_fields_t'(slot_q[FIELD_W-1:0]);
    cand_f    = from_slot ? slot_f : new_f;
    cand_arg  = from_slot ? slot_arg : arg_nx;
    out_d     = {cand_arg, cand_f.lng, cand_f.resp, cand_f.idx};
  end

  sdq_ctrl u_ctrl (
    .clk            (clk),
    .rst            (rst),
    .start_req      (start_req),
    .launch_clk_only(cand_f.clk_only),
    .eng_end        (eng_resp_i || eng_tout_i),
    .busy_o         (exec_busy),
    .slot_full_o    (slot_full),
    .from_slot_o    (from_slot),
    .launch_o       (launch),
    .push_o         (push),
    .reject_o       (reject),
    .normal_done_o  (normal_done)
  );

  sdq_slot #(.W(SLOT_W)) u_hold (
    .clk (clk),
    .rst (rst),
    .load(push),
    .d   (slot_d),
    .q   (slot_q)
  );

  sdq_slot #(.W(OUT_W)) u_issue (
    .clk (clk),
    .rst (rst),
    .load(launch && !cand_f.clk_only),
    .d   (out_d),
    .q   (out_q)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      issue_valid_o <= 1'b0;
      clk_upd_o     <= 1'b0;
    end else begin
      issue_valid_o <= launch && !cand_f.clk_only;
      clk_upd_o     <= launch && cand_f.clk_only;
    end
  end

  always_comb begin
    sts_set          = '0;
    sts_set[ST_DONE] = normal_done;
    sts_set[ST_TOUT] = normal_done && eng_tout_i;
    sts_set[ST_RERR] = normal_done && !eng_tout_i && eng_rerr_i;
    sts_set[ST_HLE]  = reject;
  end

  sdq_status #(.N(NSTS)) u_sts (
    .clk      (clk),
    .rst      (rst),
    .set_i    (sts_set),
    .clr_en_i (sts_clr_en_i),
    .clr_i    (sts_clr_data_i),
    .mask_en_i(mask_wr_en_i),
    .mask_i   (mask_wr_data_i),
    .sts_o    (status_o),
    .irq_o    (irq_o)
  );

  assign issue_arg_o     = out_q[OUT_W-1:ISS_W];
  assign issue_long_o    = out_q[IDX_W+1];
  assign issue_resp_o    = out_q[IDX_W];
  assign issue_index_o   = out_q[IDX_W-1:0];
  assign start_pending_o = slot_full;
endmodule

// File: rtl/sdq_cmd_queue_chk.sv
module sdq_cmd_queue_chk #(
  parameter int N = 4
) (
  input logic         clk,
  input logic         rst,
  input logic         issue_valid,
  input logic         clk_upd,
  input logic         start_pending,
  input logic [N-1:0] status,
  input logic         irq,
  input logic         busy
);
  // R4: launches never back to back
  assert_single_launch_R4: assert property (@(posedge clk) disable iff (rst)
    (issue_valid || clk_upd) |=> !(issue_valid || clk_upd));

  // R4: start bit falls only with a launch
  assert_start_clear_R4: assert property (@(posedge clk) disable iff (rst)
    $fell(start_pending) |-> (issue_valid || clk_upd));

  // R8: one destination per launch
  assert_launch_exclusive_R8: assert property (@(posedge clk) disable iff (rst)
    !(issue_valid && clk_upd));

  // R5: locked error only when the slot was already full
  assert_hle_needs_full_R5: assert property (@(posedge clk) disable iff (rst)
    $rose(status[3]) |-> $past(start_pending));

  // R6: done only after something executed
  assert_done_needs_busy_R6: assert property (@(posedge clk) disable iff (rst)
    $rose(status[0]) |-> $past(busy));

  // R10: interrupt needs a status source
  assert_irq_source_R10: assert property (@(posedge clk) disable iff (rst)
    irq |-> (status != '0));

  // R11: state right after reset
  assert_reset_state_R11: assert property (@(posedge clk)
    $past(rst) |-> (status == '0 && !issue_valid && !clk_upd && !start_pending && !irq));
endmodule

bind sdq_cmd_queue sdq_cmd_queue_chk #(.N(sdq_pkg::NSTS)) u_chk (
  .clk          (clk),
  .rst          (rst),
  .issue_valid  (issue_valid_o),
  .clk_upd      (clk_upd_o),
  .start_pending(start_pending_o),
  .status       (status_o),
  .irq          (irq_o),
  .busy         (exec_busy)
);

// File: tb/test_sdq_cmd_queue.sv
`timescale 1ns/1ps
module test_sdq_cmd_queue;
  localparam int ARG_W = 32;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic arg_wr_en = 0, cmd_wr_en = 0, sts_clr_en = 0, mask_wr_en = 0;
  logic [ARG_W-1:0] arg_wr_data = '0;
  logic [9:0] cmd_wr_data = '0;
  logic [3:0] sts_clr_data = '0, mask_wr_data = '0;
  logic eng_resp = 0, eng_tout = 0, eng_rerr = 0;
  logic issue_valid, issue_resp, issue_long, clk_upd, start_pending, irq;
  logic [ARG_W-1:0] issue_arg;
  logic [5:0] issue_index;
  logic [3:0] status;

  int checks = 0, failures = 0, cycles = 0;
  bit compare_on = 0;

  always #2.5 clk = ~clk;

  sdq_cmd_queue #(.ARG_W(ARG_W)) i_sdq_cmd_queue (
    .clk(clk), .rst(rst),
    .arg_wr_en_i(arg_wr_en), .arg_wr_data_i(arg_wr_data),
    .cmd_wr_en_i(cmd_wr_en), .cmd_wr_data_i(cmd_wr_data),
    .sts_clr_en_i(sts_clr_en), .sts_clr_data_i(sts_clr_data),
    .mask_wr_en_i(mask_wr_en), .mask_wr_data_i(mask_wr_data),
    .eng_resp_i(eng_resp), .eng_tout_i(eng_tout), .eng_rerr_i(eng_rerr),
    .issue_valid_o(issue_valid), .issue_arg_o(issue_arg), .issue_index_o(issue_index),
    .issue_resp_o(issue_resp), .issue_long_o(issue_long), .clk_upd_o(clk_upd),
    .start_pending_o(start_pending), .status_o(status), .irq_o(irq)
  );

  // behavioural reference model
  bit m_busy, m_clkx, m_iv, m_cu, m_irq;
  bit [31:0] m_arg, m_argreg;
  bit [9:0] m_cmd;
  bit [3:0] m_sts, m_mask;
  bit [31:0] qa[$];
  bit [9:0] qc[$];

  task automatic m_launch(input bit [9:0] c, input bit [31:0] a);
    m_busy = 1;
    m_clkx = c[8];
    if (c[8]) m_cu = 1;
    else begin m_iv = 1; m_cmd = c; m_arg = a; end
  endtask

  always @(posedge clk) begin
    bit st, fin;
    bit [31:0] an;
    bit [3:0] set;
    if (rst) begin
      m_busy = 0; m_clkx = 0; m_iv = 0; m_cu = 0; m_irq = 0;
      m_arg = 0; m_argreg = 0; m_cmd = 0; m_sts = 0; m_mask = 0;
      qa.delete(); qc.delete();
    end else begin
      m_iv = 0; m_cu = 0; set = 0;
      an = arg_wr_en ? arg_wr_data : m_argreg;
      st = cmd_wr_en && cmd_wr_data[9];
      fin = m_busy && !m_clkx && (eng_resp || eng_tout);
      if (fin) begin
        set[0] = 1;
        if (eng_tout) set[2] = 1;
        else if (eng_rerr) set[1] = 1;
      end
      if (!m_busy) begin
        if (qc.size() > 0) begin
          m_launch(qc.pop_front(), qa.pop_front());
          if (st) begin qc.push_back(cmd_wr_data); qa.push_back(an); end
        end else if (st) m_launch(cmd_wr_data, an);
      end else begin
        if (fin || m_clkx) m_busy = 0;
        if (st) begin
          if (qc.size() == 0) begin qc.push_back(cmd_wr_data); qa.push_back(an); end
          else set[3] = 1;
        end
      end
      m_argreg = an;
      m_sts = set | (m_sts & ~(sts_clr_en ? sts_clr_data : 4'h0));
      if (mask_wr_en) m_mask = mask_wr_data;
      m_irq = |(m_sts & m_mask);
    end
  end

  task automatic chk(input string req, input string what, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s %s actual=%0h expected=%0h t=%0t", req, what, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (compare_on && !rst) begin
      chk("R2", "issue_valid", issue_valid, m_iv);
      if (m_iv) begin
        chk("R2", "issue_arg", issue_arg, m_arg);
        chk("R1", "issue_fields", {issue_long, issue_resp, issue_index}, m_cmd[7:0]);
      end
      chk("R8", "clk_upd", clk_upd, m_cu);
      chk("R3", "start_pending", start_pending, qc.size() > 0);
      chk("R9", "status", status, m_sts);
      chk("R10", "irq", irq, m_irq);
    end
  end

  task automatic cyc(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic put_cmd(input bit [9:0] c, input bit wa, input bit [31:0] a);
    cmd_wr_en = 1; cmd_wr_data = c; arg_wr_en = wa; arg_wr_data = a;
    @(negedge clk);
    cmd_wr_en = 0; arg_wr_en = 0;
  endtask

  task automatic eng(input bit r, input bit t, input bit e);
    eng_resp = r; eng_tout = t; eng_rerr = e;
    @(negedge clk);
    eng_resp = 0; eng_tout = 0; eng_rerr = 0;
  endtask

  task automatic clr(input bit [3:0] v);
    sts_clr_en = 1; sts_clr_data = v;
    @(negedge clk);
    sts_clr_en = 0;
  endtask

  // watchdog
  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    cyc(3);
    rst = 0;
    compare_on = 1;
    // R11 reset state
    chk("R11", "status", status, 0);
    chk("R11", "outputs", {issue_valid, clk_upd, start_pending, irq}, 0);

    // R2 idle launch, argument forwarded from same cycle
    put_cmd(10'h200 | 10'h040 | 10'd5, 1, 32'hA1A1_0001);
    chk("R2", "issue_valid", issue_valid, 1);
    chk("R2", "issue_arg", issue_arg, 32'hA1A1_0001);
    chk("R2", "index", issue_index, 5);
    chk("R2", "start_pending", start_pending, 0);

    // R3 buffered
    put_cmd(10'h200 | 10'd7, 1, 32'hB2B2_0002);
    chk("R3", "start_pending", start_pending, 1);
    chk("R3", "no launch", issue_valid, 0);

    // R5 third command rejected
    put_cmd(10'h200 | 10'd9, 1, 32'hC3C3_0003);
    chk("R5", "hle", status[3], 1);
    chk("R5", "slot kept", start_pending, 1);

    // R4 promotion in the cycle after completion
    eng(1, 0, 0);
    chk("R6", "done", status[0], 1);
    chk("R4", "not yet", issue_valid, 0);
    cyc(1);
    chk("R4", "promoted", issue_valid, 1);
    chk("R4", "index", issue_index, 7);
    chk("R4", "arg", issue_arg, 32'hB2B2_0002);
    chk("R4", "start cleared", start_pending, 0);

    // R7 timeout
    eng(0, 1, 1);
    chk("R7", "timeout bit", status[2], 1);
    chk("R7", "rerr bit", status[1], 0);

    // R9 write one to clear
    clr(4'hF);
    chk("R9", "cleared", status, 0);

    // R1 no start bit
    put_cmd(10'd3, 0, 0);
    cyc(2);
    chk("R1", "no launch", issue_valid, 0);
    chk("R1", "no pending", start_pending, 0);

    // R6 engine inputs ignored while idle
    eng(1, 1, 0);
    chk("R6", "idle ignored", status, 0);

    // R8 clock-update-only
    put_cmd(10'h200 | 10'h100 | 10'd12, 0, 0);
    chk("R8", "clk_upd", clk_upd, 1);
    chk("R8", "no issue", issue_valid, 0);
    eng(1, 0, 0);
    cyc(2);
    chk("R8", "no status", status, 0);

    // R10 mask and irq, R7 response error
    mask_wr_en = 1; mask_wr_data = 4'h1;
    @(negedge clk);
    mask_wr_en = 0;
    put_cmd(10'h200 | 10'h040 | 10'd2, 1, 32'h2222);
    eng(1, 0, 1);
    chk("R7", "rerr", status, 4'h3);
    chk("R10", "irq", irq, 1);
    clr(4'hF);
    chk("R10", "irq low", irq, 0);

    // R9 set wins over clear
    put_cmd(10'h200 | 10'd4, 0, 0);
    sts_clr_en = 1; sts_clr_data = 4'h1;
    eng(1, 0, 0);
    sts_clr_en = 0;
    chk("R9", "set wins", status[0], 1);
    clr(4'hF);

    // random traffic against the model
    for (int i = 0; i < 4000; i++) begin
      int r;
      r = $urandom_range(0, 99);
      cmd_wr_en    = (r < 30);
      cmd_wr_data  = 10'($urandom);
      if (r < 25) cmd_wr_data[9] = 1;
      cmd_wr_data[8] = ($urandom_range(0, 9) == 0);
      arg_wr_en    = ($urandom_range(0, 2) == 0);
      arg_wr_data  = $urandom;
      eng_resp     = ($urandom_range(0, 5) == 0);
      eng_tout     = ($urandom_range(0, 11) == 0);
      eng_rerr     = $urandom_range(0, 1);
      sts_clr_en   = ($urandom_range(0, 7) == 0);
      sts_clr_data = 4'($urandom);
      mask_wr_en   = ($urandom_range(0, 31) == 0);
      mask_wr_data = 4'($urandom);
      @(negedge clk);
    end
    cmd_wr_en = 0; arg_wr_en = 0; eng_resp = 0; eng_tout = 0;
    sts_clr_en = 0; mask_wr_en = 0;
    cyc(4);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule